// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

A memory-mapped watchdog that counts while enabled and asks for a chip reset when software stops servicing it. The timeout is set by a power-of-two postscaler. The input clock always passes through a fixed divide-by-32 stage first, so a postscaler value `p` gives a timeout of `32 * 2^p` clock cycles. Software restarts the count only by writing a 16-bit key into the upper half of the control word. A stray store, or a write of any other value, leaves the count alone.

Two registers sit on a simple one-cycle write bus: a control word and a reset-cause word. Each one has a plain write address, a clear alias and a set alias. Every expiry raises a one-cycle reset request, restarts the count, and records the cause in sticky flags. Those flags stay set until software clears them through the clear alias. The clock-source selection is stored and driven out for an external mux. Windowed clearing is only reported from an input pin, and the sleep and idle power states arrive as plain inputs.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the control word reads 0 apart from bit 0, the status word reads 0 and `rst_req_o` is low.
- R2: Control bits: 15 enable, 12:8 postscaler, 7:6 clock select (driven on `clk_sel_o`), 0 mirrors `window_i` and is read-only; all other bits read 0.
- R3: `word_addr_i[2]` picks the register (0 control, 1 status) and `word_addr_i[1:0]` picks the access: 0 plain write, 1 clear alias (written ones clear bits), 2 set alias (written ones set bits), 3 ignored. Only byte lanes with `be_i` high take part.
- R4: With postscaler `p`, `rst_req_o` rises exactly `32 * 2^p` clock edges after the edge that enables the timer or services it.
- R5: A service happens only for a plain control write with `be_i == 4'b1100` and `wdata_i[31:16] == 16'h5743`. A service restarts the count from zero. Any other value, lane pattern or address leaves the count unchanged.
- R6: Each expiry gives a `rst_req_o` pulse one cycle long and restarts the count, so expiries repeat every `32 * 2^p` cycles while the timer stays enabled and unserviced.
- R7: While the timer is disabled the count holds at zero and no request is raised; re-enabling starts a full period.
- R8: On expiry, status bit 4 is set, bit 3 is set if `sleep_i` is high and bit 2 is set if `idle_i` is high. The flags are sticky.
- R9: Status bits clear only through the clear alias by writing ones; plain and set-alias writes to the status word are ignored; an expiry in the same cycle as a clear leaves the flag set.
- R10: Any write in the cycle right after a write that clears the enable bit is ignored.
- R11: `window_i` only affects the read-back of bit 0; servicing behaves the same with it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access valid |
| we_i | input | 1 | Write strobe |
| word_addr_i | input | 3 | Word address: bit 2 register, bits 1:0 access kind |
| be_i | input | 4 | Byte-lane enables |
| wdata_i | input | 32 | Write data |
| window_i | input | 1 | Windowed-clear configuration, read back on control bit 0 |
| idle_i | input | 1 | Core is in idle state |
| sleep_i | input | 1 | Core is in sleep state |
| rdata_o | output | 32 | Read data for `word_addr_i`, combinational |
| clk_sel_o | output | 2 | Clock-source selection for the external mux |
| rst_req_o | output | 1 | One-cycle reset request on expiry |

## Verification
The bound checker watches several properties on every cycle. A request pulse lasts one cycle and always comes with the timeout flag. A disabled timer keeps its count at zero and raises no request. A service zeroes the count. The control word is frozen during the post-disable blackout, and the timeout flag stays set unless the clear alias hits it. The exact period for each postscaler value, the rejection of near-miss keys, the sleep and idle cause bits, byte-lane masking and the clear-versus-expiry collision depend on precise timing and stimulus, so only the bench's directed scenarios can show them.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int unsigned DW       = 32;
  localparam int unsigned PRE_LOG2 = 5;   // fixed divide-by-32
  localparam int unsigned PS_W     = 5;
  localparam int unsigned CS_W     = 2;
  localparam int unsigned EN_BIT   = 15;
  localparam int unsigned PS_LSB   = 8;
  localparam int unsigned CS_LSB   = 6;
  localparam int unsigned ST_IDLE  = 2;
  localparam int unsigned ST_SLEEP = 3;
  localparam int unsigned ST_WDT   = 4;
  localparam logic [15:0]   SVC_KEY    = 16'h5743;
  localparam logic [3:0]    SVC_LANES  = 4'b1100;
  localparam logic [DW-1:0] CTRL_WMASK = 32'h0000_9FC0;
  localparam logic [DW-1:0] STAT_MASK  = 32'h0000_001C;

  typedef enum logic [1:0] {
    ACC_RAW = 2'd0,
    ACC_CLR = 2'd1,
    ACC_SET = 2'd2,
    ACC_RSV = 2'd3
  } acc_e;
endpackage

// File: rtl/kwdt_prediv.sv
module kwdt_prediv #(
  parameter int unsigned LOG2 = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  output logic tick_o
);
  logic [LOG2-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pre_q <= '0;
    else if (!en_i || clr_i)  pre_q <= '0;
    else                      pre_q <= pre_q + 1'b1;
  end

  // a service in the last prescaler cycle wins over the tick
  assign tick_o = en_i && (&pre_q) && !clr_i;
endmodule

// File: rtl/kwdt_expiry.sv
module kwdt_expiry #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned PS_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [PS_W-1:0]  ps_i,
  output logic             expire_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term_m1;

  assign term_m1  = (CNT_W'(1) << ps_i) - CNT_W'(1);
  assign expire_o = tick_i && (cnt_q == term_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (!en_i || clr_i || expire_o)  cnt_q <= '0;
    else if (tick_i)                      cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/kwdt_regfile.sv
module kwdt_regfile
  import kwdt_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [2:0]      word_addr_i,
  input  logic [3:0]      be_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            window_i,
  input  logic            idle_i,
  input  logic            sleep_i,
  input  logic            expire_i,
  output logic            en_o,
  output logic [PS_W-1:0] ps_o,
  output logic [CS_W-1:0] cs_o,
  output logic            svc_o,
  output logic            blk_o,
  output logic [DW-1:0]   stat_o,
  output logic [DW-1:0]   rdata_o
);
  logic [DW-1:0] ctrl_q, ctrl_d, stat_q, stat_d;
  logic [DW-1:0] lane_m, wbits, cmask, stat_clr, stat_set;
  logic          blk_q, wr, sel_stat;
  acc_e          acc;

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign lane_m[8*g +: 8] = {8{be_i[g]}};
  end

  assign wr       = req_i && we_i && !blk_q;
  assign sel_stat = word_addr_i[2];
  assign acc      = acc_e'(word_addr_i[1:0]);
  assign wbits    = wdata_i & lane_m;
  assign cmask    = CTRL_WMASK & lane_m;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr && !sel_stat) begin
      unique case (acc)
        ACC_RAW: ctrl_d = (ctrl_q & ~cmask) | (wbits & CTRL_WMASK);
        ACC_CLR: ctrl_d = ctrl_q & ~(wbits & CTRL_WMASK);
        ACC_SET: ctrl_d = ctrl_q | (wbits & CTRL_WMASK);
        default: ctrl_d = ctrl_q;
      endcase
    end
  end

  always_comb begin
    stat_clr = (wr && sel_stat && acc == ACC_CLR) ? (wbits & STAT_MASK) : '0;
    stat_set = '0;
    if (expire_i) begin
      stat_set[ST_WDT]   = 1'b1;
      stat_set[ST_SLEEP] = sleep_i;
      stat_set[ST_IDLE]  = idle_i;
    end
    stat_d = (stat_q & ~stat_clr) | stat_set;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      stat_q <= '0;
      blk_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      stat_q <= stat_d;
      blk_q  <= ctrl_q[EN_BIT] && !ctrl_d[EN_BIT];
    end
  end

  assign svc_o = wr && !sel_stat && acc == ACC_RAW && be_i == SVC_LANES
              && wdata_i[31:16] == SVC_KEY;

  assign en_o    = ctrl_q[EN_BIT];
  assign ps_o    = ctrl_q[PS_LSB +: PS_W];
  assign cs_o    = ctrl_q[CS_LSB +: CS_W];
  assign blk_o   = blk_q;
  assign stat_o  = stat_q;
  assign rdata_o = sel_stat ? stat_q : {ctrl_q[DW-1:1], window_i};
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import kwdt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [2:0]    word_addr_i,
  input  logic [3:0]    be_i,
  input  logic [31:0]   wdata_i,
  input  logic          window_i,
  input  logic          idle_i,
  input  logic          sleep_i,
  output logic [31:0]   rdata_o,
  output logic [1:0]    clk_sel_o,
  output logic          rst_req_o
);
  logic            en, svc, blk, tick, expire, rst_req_q;
  logic [PS_W-1:0] ps;
  logic [DW-1:0]   stat;
  logic [CNT_W-1:0] cnt;

  kwdt_regfile u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .word_addr_i, .be_i, .wdata_i,
    .window_i, .idle_i, .sleep_i,
    .expire_i (expire),
    .en_o     (en),
    .ps_o     (ps),
    .cs_o     (clk_sel_o),
    .svc_o    (svc),
    .blk_o    (blk),
    .stat_o   (stat),
    .rdata_o  (rdata_o)
  );

  kwdt_prediv #(.LOG2(PRE_LOG2)) u_pre (
    .clk_i, .rst_ni,
    .en_i   (en),
    .clr_i  (svc),
    .tick_o (tick)
  );

  kwdt_expiry #(.CNT_W(CNT_W), .PS_W(PS_W)) u_exp (
    .clk_i, .rst_ni,
    .en_i     (en),
    .clr_i    (svc),
    .tick_i   (tick),
    .ps_i     (ps),
    .expire_o (expire),
    .cnt_o    (cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_req_q <= 1'b0;
    else         rst_req_q <= expire;
  end

  assign rst_req_o = rst_req_q;
endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [2:0]       word_addr_i,
  input logic [3:0]       be_i,
  input logic [31:0]      wdata_i,
  input logic             rst_req_o,
  input logic             en,
  input logic             svc,
  input logic             blk,
  input logic [CNT_W-1:0] cnt,
  input logic [31:0]      stat,
  input logic [31:0]      rdata_ctrl_en
);
  logic clr_hits_wdt;
  assign clr_hits_wdt = req_i && we_i && word_addr_i == 3'b101 && be_i[0] && wdata_i[4];

  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
  a_r8_flag_with_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> stat[4]);
  a_r7_held_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> cnt == '0);
  a_r7_no_req_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> !rst_req_o);
  a_r5_service_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc |=> cnt == '0);
  a_r10_blackout_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk |=> $stable(rdata_ctrl_en));
  a_r9_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat[4] && !clr_hits_wdt) |=> stat[4]);
endmodule

bind keyed_wdt kwdt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .req_i, .we_i, .word_addr_i, .be_i, .wdata_i, .rst_req_o,
  .en            (en),
  .svc           (svc),
  .blk           (blk),
  .cnt           (cnt),
  .stat          (stat),
  .rdata_ctrl_en ({16'h0, en, 2'b00, ps, clk_sel_o, 6'h00})
);

// File: tb/keyed_wdt_test.sv
module keyed_wdt_test;
  timeunit 1ns; timeprecision 1ps;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_CTRL = 3'd0, A_CCLR = 3'd1, A_CSET = 3'd2;
  localparam logic [2:0] A_STAT = 3'd4, A_SCLR = 3'd5, A_SSET = 3'd6;
  localparam int NVEC = 6;
  // {postscaler, cycles before a key write (0 = none)}
  localparam logic [20:0] VEC [NVEC] = '{
    {5'd0, 16'd0}, {5'd1, 16'd0}, {5'd2, 16'd10},
    {5'd3, 16'd200}, {5'd4, 16'd0}, {5'd2, 16'd126}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, we = 0, window = 0, idle = 0, sleep = 0;
  logic [2:0] addr = '0;
  logic [3:0] be = '0;
  logic [31:0] wdata = '0, rdata;
  logic [1:0] clk_sel;
  logic rst_req;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_wdt uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .word_addr_i(addr),
    .be_i(be), .wdata_i(wdata), .window_i(window), .idle_i(idle), .sleep_i(sleep),
    .rdata_o(rdata), .clk_sel_o(clk_sel), .rst_req_o(rst_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge
  task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [3:0] b);
    req = 1; we = 1; addr = a; wdata = d; be = b;
    @(negedge clk);
    req = 0; we = 0; be = '0; wdata = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic quiet(input int n, input string tag);
    logic seen = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (rst_req) seen = 1;
    end
    chk(tag, 32'(seen), 0);
  endtask

  task automatic expect_pulse(input int n, input string tag);
    quiet(n - 1, tag);
    @(negedge clk);
    chk(tag, 32'(rst_req), 1);
  endtask

  task automatic stop_timer();
    wr(A_CCLR, 32'h8000, 4'b1111);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    rd_chk("R1 ctrl", A_CTRL, 0);
    rd_chk("R1 stat", A_STAT, 0);
    chk("R1 req", 32'(rst_req), 0);
    rst_n = 1;
    @(negedge clk);

    // vector walk: R4 period, R6 repeat, R8 flag, R9 clear
    for (int i = 0; i < NVEC; i++) begin
      logic [4:0] ps = VEC[i][20:16];
      int d = int'(VEC[i][15:0]);
      int n = 32 << ps;
      wr(A_CTRL, {16'h0, 1'b1, 2'b00, ps, 8'h00}, 4'b1111);
      rd_chk("R2 ctrl", A_CTRL, {16'h0, 1'b1, 2'b00, ps, 8'h00});
      if (d > 0) begin
        quiet(d, "R4 early");
        wr(A_CTRL, {16'h5743, 16'h0}, 4'b1100);
      end
      expect_pulse(n, "R4 period");
      expect_pulse(n, "R6 repeat");
      stop_timer();
      rd_chk("R8 flag", A_STAT, 32'h10);
      wr(A_SCLR, 32'h10, 4'b1111);
      rd_chk("R9 clear", A_STAT, 0);
    end

    // R2 field layout and read-only window bit
    wr(A_CTRL, 32'hFFFF_FFFF, 4'b1111);
    rd_chk("R2 all ones", A_CTRL, 32'h9FC0);
    chk("R2 clk_sel", 32'(clk_sel), 3);
    wr(A_CCLR, 32'hFFFF_FFFF, 4'b1111);
    @(negedge clk);
    rd_chk("R2 cleared", A_CTRL, 0);

    // R3 aliases and byte lanes
    wr(A_CSET, 32'h0000_FFFF, 4'b0001);
    rd_chk("R3 lane0 set", A_CTRL, 32'hC0);
    wr(A_CCLR, 32'hFF, 4'b0001);
    wr(A_CSET, 32'h300, 4'b1111);
    rd_chk("R3 set", A_CTRL, 32'h300);
    wr(A_CCLR, 32'h100, 4'b1111);
    rd_chk("R3 clr", A_CTRL, 32'h200);
    wr(A_CTRL, 32'h40, 4'b1111);
    rd_chk("R3 plain", A_CTRL, 32'h40);
    wr(3'd3, 32'h8000, 4'b1111);
    rd_chk("R3 reserved", A_CTRL, 32'h40);
    wr(A_CTRL, 32'h0, 4'b1111);

    // R5 near-miss keys do not restart
    wr(A_CTRL, 32'h8000, 4'b1111);
    wr(A_CTRL, {16'h5744, 16'h0}, 4'b1100);
    wr(A_CTRL, 32'h5743_8000, 4'b1111);
    wr(A_STAT, {16'h5743, 16'h0}, 4'b1100);
    expect_pulse(29, "R5 bad key");
    quiet(10, "R5 early");
    wr(A_CTRL, {16'h5743, 16'h0}, 4'b1100);
    expect_pulse(32, "R5 good key");
    stop_timer();
    wr(A_SCLR, 32'h1C, 4'b1111);

    // R7 disabled holds
    wr(A_CTRL, 32'h0000_8100, 4'b1111);
    quiet(20, "R7 run");
    stop_timer();
    quiet(200, "R7 held");
    rd_chk("R7 no flag", A_STAT, 0);
    wr(A_CSET, 32'h8000, 4'b1111);
    expect_pulse(64, "R7 restart");
    stop_timer();
    wr(A_SCLR, 32'h1C, 4'b1111);

    // R8 cause bits, R9 ignored writes
    sleep = 1;
    wr(A_CTRL, 32'h8000, 4'b1111);
    expect_pulse(32, "R8 sleep");
    stop_timer();
    rd_chk("R8 sleep flags", A_STAT, 32'h18);
    wr(A_STAT, 32'h0, 4'b1111);
    rd_chk("R9 plain ignored", A_STAT, 32'h18);
    wr(A_SSET, 32'h1C, 4'b1111);
    rd_chk("R9 set ignored", A_STAT, 32'h18);
    wr(A_SCLR, 32'h08, 4'b1111);
    rd_chk("R9 partial", A_STAT, 32'h10);
    wr(A_SCLR, 32'h10, 4'b1111);
    sleep = 0; idle = 1;
    wr(A_CTRL, 32'h8000, 4'b1111);
    expect_pulse(32, "R8 idle");
    stop_timer();
    rd_chk("R8 idle flags", A_STAT, 32'h14);
    wr(A_SCLR, 32'h1C, 4'b1111);
    idle = 0;

    // R9 expiry wins over clear in the same cycle
    wr(A_CTRL, 32'h8000, 4'b1111);
    repeat (31) @(negedge clk);
    wr(A_SCLR, 32'h10, 4'b1111);
    chk("R9 collide req", 32'(rst_req), 1);
    rd_chk("R9 collide flag", A_STAT, 32'h10);
    stop_timer();
    wr(A_SCLR, 32'h10, 4'b1111);

    // R10 blackout after disable
    wr(A_CTRL, 32'h8000, 4'b1111);
    wr(A_CCLR, 32'h8000, 4'b1111);
    wr(A_CSET, 32'h8000, 4'b1111);
    rd_chk("R10 ignored", A_CTRL, 0);
    quiet(100, "R10 stopped");
    wr(A_CSET, 32'h8000, 4'b1111);
    rd_chk("R10 later ok", A_CTRL, 32'h8000);
    stop_timer();

    // R11 window bit only reads back
    window = 1;
    rd_chk("R11 window", A_CTRL, 1);
    wr(A_CCLR, 32'h1, 4'b1111);
    rd_chk("R11 ro", A_CTRL, 1);
    wr(A_CTRL, 32'h8000, 4'b1111);
    quiet(19, "R11 early");
    wr(A_CTRL, {16'h5743, 16'h0}, 4'b1100);
    expect_pulse(32, "R11 service");
    stop_timer();
    window = 0;

    finish_run();
  end
endmodule